// File: doc/BRIEF.md
# Programmable Tap-Based Timing Generator

This block produces the timing pulse lines that clock the pin channels of a chip tester. Each test cycle is split into fine time steps by a step counter. The counter stands in for a tapped delay line. Every pulse line has its own tap register, which names the step at which the line goes high. The line then stays high until the cycle ends. A reserved tap code disconnects a line from the counter and ties it to a fixed level. That code is the reset value, so lines the host never programs stay quietly low.

The lines come in pairs. Inside the block, line p of a pair acts as the mux clock and line p + N_PAIRS acts as the shift clock. Host line indices are interleaved: host index 0 selects line 0, index 1 selects line N_PAIRS, index 2 selects line 1, and so on. The reference clock is either an internal or an external source. The choice is made ahead of every register, so the external clock also drives the counter and the control logic. A start input launches either free-running cycles or exactly one cycle. A done pulse marks the end of each cycle.

Top module: `tap_timing_gen`

## Requirements
- R1: While rst_n is low, mux_clk, shift_clk and done are all 0.
- R2: When mode bit 0 is 1, all sequencing advances only on rising edges of ext_clk. With ext_clk static, no output changes, whatever start and int_clk do. When mode bit 0 is 0, int_clk is used. Reset selects int_clk.
- R3: A started cycle visits steps 0 through the programmed length L, one step per clock. The done output is high in the clock after step L, one clock per completed cycle.
- R4: A line whose tap value T (bits STEP_W-1:0) is not the reserved code goes high in the clock where the step equals T. It stays high through step L and is low at step 0 of the next cycle and whenever no cycle is running.
- R5: A tap register whose low STEP_W bits are all ones is the no-tap code. Its line is held at the value of tap bit STEP_W, whether or not a cycle is running.
- R6: After reset, every tap register holds the no-tap code with level bit 0, so every line is low until it is programmed.
- R7: Host writes use wr_addr. An address k below 2*N_PAIRS writes the tap of line k/2 when k is even and line N_PAIRS + (k-1)/2 when k is odd. Address 2*N_PAIRS writes the cycle length L from wr_data[STEP_W-1:0]. Address 2*N_PAIRS+1 writes the mode: bit 0 selects the external clock and bit 1 selects single-cycle mode.
- R8: mux_clk[p] carries line p and shift_clk[p] carries line p + N_PAIRS.
- R9: In single-cycle mode, start launches exactly one cycle. A further cycle needs start to be seen low first.
- R10: In free-run mode, cycles repeat while start is high at each cycle's end. After start is seen low there, the block goes idle.
- R11: A tap value greater than L never raises its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| int_clk | input | 1 | Internal reference clock |
| ext_clk | input | 1 | External reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | $clog2(2*N_PAIRS)+1 | Host write address |
| wr_data | input | STEP_W+1 | Host write data |
| start | input | 1 | Launch / continue cycles |
| mux_clk | output | N_PAIRS | Lower line of each pair |
| shift_clk | output | N_PAIRS | Upper line of each pair |
| done | output | 1 | End-of-cycle pulse |

## Verification
The embedded properties check on every clock that each line rises on its tap step and is low when idle, that no-tap lines follow their level bit, that done follows the last step, and that single mode ends in the hold state. Only the bench scenarios can show the following:
- the interleaved host numbering and the pair mapping at the outputs;
- the exact count of cycles in free-run and single-cycle modes;
- that a static external clock freezes the whole sequencer;
- that a clean switch back to the internal clock loses no state.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_RUN  = 2'd1,
    SQ_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/tg_rst_sync.sv
module tg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/tg_regs.sv
module tg_regs #(
  parameter int N_LINES = 16,
  parameter int STEP_W  = 6,
  localparam int TAP_W  = STEP_W + 1,
  localparam int ADDR_W = $clog2(N_LINES) + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [TAP_W-1:0]                wr_data,
  output logic [N_LINES-1:0][TAP_W-1:0]   taps,
  output logic [STEP_W-1:0]               cyc_len,
  output logic                            clk_ext,
  output logic                            single
);
  localparam int HALF     = N_LINES / 2;
  localparam int LEN_ADDR = N_LINES;
  localparam int MODE_ADDR = N_LINES + 1;

  // one tap register per internal line; host index is interleaved
  for (genvar i = 0; i < N_LINES; i++) begin : g_tap
    localparam int HOST = (i < HALF) ? 2 * i : 2 * (i - HALF) + 1;
    logic             hit;
    logic [TAP_W-1:0] tap_q;
    assign hit = wr_en && (wr_addr == ADDR_W'(HOST));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   tap_q <= {1'b0, {STEP_W{1'b1}}};
      else if (hit) tap_q <= wr_data;
    end
    assign taps[i] = tap_q;
  end

  logic len_hit, mode_hit;
  logic [STEP_W-1:0] len_q;
  logic [1:0]        mode_q;

  assign len_hit  = wr_en && (wr_addr == ADDR_W'(LEN_ADDR));
  assign mode_hit = wr_en && (wr_addr == ADDR_W'(MODE_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '1;
      mode_q <= 2'b00;
    end else begin
      if (len_hit)  len_q  <= wr_data[STEP_W-1:0];
      if (mode_hit) mode_q <= wr_data[1:0];
    end
  end

  assign cyc_len = len_q;
  assign clk_ext = mode_q[0];
  assign single  = mode_q[1];

  p_len_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    len_hit |=> (cyc_len == $past(wr_data[STEP_W-1:0])));
endmodule

// File: rtl/tg_seq.sv
module tg_seq
  import tg_pkg::*;
#(
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              single,
  input  logic [STEP_W-1:0] cyc_len,
  output logic              run_d,
  output logic [STEP_W-1:0] step_d,
  output logic              run_q,
  output logic [STEP_W-1:0] step_q,
  output logic              done
);
  seq_state_e state_q, state_d;
  logic       done_d;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    done_d  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_RUN;
          step_d  = '0;
        end
      end
      SQ_RUN: begin
        if (step_q == cyc_len) begin
          done_d = 1'b1;
          step_d = '0;
          if (single)      state_d = SQ_HOLD;
          else if (!start) state_d = SQ_IDLE;
        end else begin
          step_d = step_q + 1'b1;
        end
      end
      SQ_HOLD: begin
        if (!start) state_d = SQ_IDLE;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      done    <= done_d;
    end
  end

  assign run_d = (state_d == SQ_RUN);
  assign run_q = (state_q == SQ_RUN);

  p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step_q == cyc_len) |=> done);
  p_no_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !done);
  p_single_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step_q == cyc_len && single) |=> (state_q == SQ_HOLD));
endmodule

// File: rtl/tg_line.sv
module tg_line #(
  parameter int STEP_W = 6,
  localparam int TAP_W = STEP_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAP_W-1:0]  tap,
  input  logic              run_d,
  input  logic [STEP_W-1:0] step_d,
  input  logic              run_q,
  input  logic [STEP_W-1:0] step_q,
  output logic              line
);
  logic notap, line_d;

  assign notap  = &tap[STEP_W-1:0];
  assign line_d = notap ? tap[STEP_W] : (run_d && (step_d >= tap[STEP_W-1:0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= 1'b0;
    else        line <= line_d;
  end

  p_rise_at_tap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !notap && step_q == tap[STEP_W-1:0] && $stable(tap)) |-> line);
  p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !notap && $stable(tap)) |-> !line);
  p_jam_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (notap && $stable(tap)) |-> (line == tap[STEP_W]));
endmodule

// File: rtl/tap_timing_gen.sv
module tap_timing_gen #(
  parameter int N_PAIRS = 8,
  parameter int STEP_W  = 6,
  localparam int N_LINES = 2 * N_PAIRS,
  localparam int TAP_W   = STEP_W + 1,
  localparam int ADDR_W  = $clog2(N_LINES) + 1
) (
  input  logic               int_clk,
  input  logic               ext_clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [TAP_W-1:0]   wr_data,
  input  logic               start,
  output logic [N_PAIRS-1:0] mux_clk,
  output logic [N_PAIRS-1:0] shift_clk,
  output logic               done
);
  logic                          clk_ext, single, core_clk, core_rst_n;
  logic [N_LINES-1:0][TAP_W-1:0] taps;
  logic [STEP_W-1:0]             cyc_len, step_d, step_q;
  logic                          run_d, run_q;
  logic [N_LINES-1:0]            lines;

  // selection sits ahead of every register, including the selector itself
  assign core_clk = clk_ext ? ext_clk : int_clk;

  tg_rst_sync u_rst (
    .clk        (core_clk),
    .rst_n      (rst_n),
    .rst_n_sync (core_rst_n)
  );

  tg_regs #(.N_LINES(N_LINES), .STEP_W(STEP_W)) u_regs (
    .clk     (core_clk),
    .rst_n   (core_rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .taps    (taps),
    .cyc_len (cyc_len),
    .clk_ext (clk_ext),
    .single  (single)
  );

  tg_seq #(.STEP_W(STEP_W)) u_seq (
    .clk     (core_clk),
    .rst_n   (core_rst_n),
    .start   (start),
    .single  (single),
    .cyc_len (cyc_len),
    .run_d   (run_d),
    .step_d  (step_d),
    .run_q   (run_q),
    .step_q  (step_q),
    .done    (done)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    tg_line #(.STEP_W(STEP_W)) u_line (
      .clk    (core_clk),
      .rst_n  (core_rst_n),
      .tap    (taps[i]),
      .run_d  (run_d),
      .step_d (step_d),
      .run_q  (run_q),
      .step_q (step_q),
      .line   (lines[i])
    );
  end

  assign mux_clk   = lines[N_PAIRS-1:0];
  assign shift_clk = lines[N_LINES-1:N_PAIRS];
endmodule

// File: tb/tap_timing_gen_tb.sv
module tap_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NL = 16;
  localparam int SW = 6;
  localparam int LEN_A  = 16;
  localparam int MODE_A = 17;

  logic int_clk = 1'b0, ext_clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, start = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [NP-1:0] mux_clk, shift_clk;
  logic done;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD/2) int_clk = ~int_clk;

  tap_timing_gen dut_i (
    .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .start(start),
    .mux_clk(mux_clk), .shift_clk(shift_clk), .done(done)
  );

  // ---------------- behavioural reference model ----------------
  int m_tap[NL];
  int m_len, m_sel, m_single, m_state, m_step, m_sync;
  bit m_line[NL];
  bit m_done;
  logic tb_core;
  bit chk_en = 1'b0;

  assign tb_core = (m_sel != 0) ? ext_clk : int_clk;

  function automatic int host_to_line(int k);
    return (k % 2 == 0) ? k / 2 : NP + k / 2;
  endfunction

  always @(posedge tb_core or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin m_tap[i] = 63; m_line[i] = 0; end
      m_len = 63; m_sel = 0; m_single = 0; m_state = 0; m_step = 0;
      m_done = 0; m_sync = 0;
    end else if (m_sync < 2) begin
      m_sync++;
    end else begin
      int ns, nstep;
      bit nd;
      ns = m_state; nstep = m_step; nd = 0;
      if (m_state == 0) begin
        if (start) begin ns = 1; nstep = 0; end
      end else if (m_state == 1) begin
        if (m_step == m_len) begin
          nd = 1; nstep = 0;
          if (m_single != 0) ns = 2;
          else if (!start)   ns = 0;
        end else nstep = (m_step + 1) % 64;
      end else if (!start) ns = 0;
      for (int i = 0; i < NL; i++) begin
        if ((m_tap[i] % 64) == 63) m_line[i] = ((m_tap[i] / 64) % 2) != 0;
        else m_line[i] = (ns == 1) && (nstep >= (m_tap[i] % 64));
      end
      if (wr_en) begin
        if (wr_addr < NL)            m_tap[host_to_line(int'(wr_addr))] = int'(wr_data);
        else if (wr_addr == LEN_A)   m_len = int'(wr_data) % 64;
        else if (wr_addr == MODE_A) begin
          m_sel = int'(wr_data[0]); m_single = int'(wr_data[1]);
        end
      end
      m_state = ns; m_step = nstep; m_done = nd;
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic [NP-1:0] em, es;
    for (int p = 0; p < NP; p++) begin em[p] = m_line[p]; es[p] = m_line[p+NP]; end
    check(mux_clk == em, "R4 R8 mux_clk vs model", int'(mux_clk), int'(em));
    check(shift_clk == es, "R4 R8 shift_clk vs model", int'(shift_clk), int'(es));
    check(done == m_done, "R3 done vs model", int'(done), int'(m_done));
  endtask

  always @(negedge int_clk) if (chk_en && m_sel == 0) compare_model();

  task automatic host_wr(int a, int d);
    @(negedge int_clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 7'(d);
    @(negedge int_clk);
    wr_en = 1'b0;
  endtask

  task automatic ext_pulse();
    ext_clk = 1'b1; #(CLK_PERIOD/2);
    ext_clk = 1'b0; #(CLK_PERIOD/2);
    compare_model();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int first_done, dcnt, rise0, hi0, rise1, rise_s0, hi2;
    logic [NP-1:0] snap_m, snap_s;
    // R1: outputs during reset
    #(CLK_PERIOD * 3);
    check(mux_clk == 0, "R1 mux_clk in reset", int'(mux_clk), 0);
    check(shift_clk == 0, "R1 shift_clk in reset", int'(shift_clk), 0);
    check(done == 0, "R1 done in reset", int'(done), 0);
    @(negedge int_clk); rst_n = 1'b1;
    repeat (4) @(negedge int_clk);
    chk_en = 1'b1;
    // R6: defaults keep lines low even when a cycle runs
    start = 1'b1;
    repeat (3) @(negedge int_clk);
    check(mux_clk == 0 && shift_clk == 0, "R6 unprogrammed lines low while running",
          int'({mux_clk, shift_clk}), 0);
    start = 1'b0;
    repeat (70) @(negedge int_clk);

    // R5/R7/R8: host index 5 -> line 10 -> shift_clk[2], jam high while idle
    host_wr(5, 7'h7F);
    @(negedge int_clk);
    check(shift_clk == 8'h04 && mux_clk == 0, "R5 R7 R8 jam high on host index 5",
          int'({mux_clk, shift_clk}), 4);
    host_wr(6, 7'h3F);                  // line 3 explicit jam low (R5)
    host_wr(LEN_A, 9);
    host_wr(0, 2);                      // line 0  -> mux_clk[0]
    host_wr(1, 5);                      // line 8  -> shift_clk[0]
    host_wr(2, 0);                      // line 1  -> mux_clk[1]
    host_wr(3, 9);                      // line 9  -> shift_clk[1]
    host_wr(4, 12);                     // line 2  -> mux_clk[2], beyond length
    host_wr(MODE_A, 2);                 // single-cycle, internal clock
    @(negedge int_clk);

    // R9/R3/R4/R11: start held high, exactly one cycle
    start = 1'b1;
    first_done = 0; dcnt = 0; rise0 = 0; hi0 = 0; rise1 = 0; rise_s0 = 0; hi2 = 0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge int_clk);
      if (done) begin dcnt++; if (first_done == 0) first_done = k; end
      if (mux_clk[0]) begin hi0++; if (rise0 == 0) rise0 = k; end
      if (mux_clk[1] && rise1 == 0) rise1 = k;
      if (shift_clk[0] && rise_s0 == 0) rise_s0 = k;
      if (mux_clk[2]) hi2++;
    end
    check(dcnt == 1, "R9 one cycle per start in single mode", dcnt, 1);
    check(first_done == 11, "R3 done one clock after step L", first_done, 11);
    check(rise0 == 3, "R4 mux_clk[0] rises at tap 2", rise0, 3);
    check(hi0 == 8, "R4 mux_clk[0] high through end of cycle", hi0, 8);
    check(rise1 == 1, "R7 host index 2 drives line 1 at step 0", rise1, 1);
    check(rise_s0 == 6, "R8 shift_clk[0] is line 8, tap 5", rise_s0, 6);
    check(hi2 == 0, "R11 tap beyond length never rises", hi2, 0);
    start = 1'b0;
    repeat (2) @(negedge int_clk);
    start = 1'b1;
    dcnt = 0;
    for (int k = 1; k <= 15; k++) begin @(negedge int_clk); if (done) dcnt++; end
    check(dcnt == 1, "R9 relaunch after start seen low", dcnt, 1);
    start = 1'b0;
    repeat (3) @(negedge int_clk);

    // R10: free run, start high for 30 clocks -> three cycles
    host_wr(MODE_A, 0);
    @(negedge int_clk);
    start = 1'b1;
    dcnt = 0;
    for (int k = 1; k <= 50; k++) begin
      @(negedge int_clk);
      if (k == 30) start = 1'b0;
      if (done) dcnt++;
    end
    check(dcnt == 3, "R10 free-run cycles while start high", dcnt, 3);
    check(mux_clk[1] == 0, "R10 idle after start dropped", int'(mux_clk[1]), 0);

    // R2: external clock drives everything
    host_wr(MODE_A, 1);
    @(negedge int_clk);
    start = 1'b1;
    snap_m = mux_clk; snap_s = shift_clk;
    dcnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge int_clk);
      if (done || mux_clk != snap_m || shift_clk != snap_s) dcnt++;
    end
    check(dcnt == 0, "R2 static ext_clk freezes sequencer", dcnt, 0);
    dcnt = 0;
    for (int k = 1; k <= 12; k++) begin ext_pulse(); if (done) dcnt++; end
    check(dcnt == 1, "R2 cycle advances on ext_clk edges", dcnt, 1);
    check(mux_clk[1] == 1, "R2 lines follow ext_clk steps", int'(mux_clk[1]), 1);
    start = 1'b0;
    for (int k = 0; k < 12; k++) ext_pulse();
    // switch back to internal clock with ext_clk left high
    wr_en = 1'b1; wr_addr = 5'(MODE_A); wr_data = 7'd0;
    #1; ext_clk = 1'b1; #1; wr_en = 1'b0;
    #(CLK_PERIOD);
    ext_clk = 1'b0;
    start = 1'b1;
    dcnt = 0;
    for (int k = 1; k <= 12; k++) begin @(negedge int_clk); if (done) dcnt++; end
    check(dcnt == 1, "R2 internal clock restored", dcnt, 1);
    start = 1'b0;
    repeat (15) @(negedge int_clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule